// File: doc/BRIEF.md
# Segment Column Data Loader

This block is the digital front end of a cascadable column driver for a dot-matrix LCD with 160 outputs. A display controller places pixel data on a shared bus, either four or eight bits per shift strobe. The chip fills its 160-bit data latch from either end. When a line latch pulse falls, that line moves into a line latch. The line latch, a frame-inversion input and an active-low blanking input then give one 2-bit drive-level code per output column. The analog output stage takes these codes.

Several chips share one bus through an enable chain. After a latch pulse, a chip waits until its enable input is low. It then takes data on every strobe and counts the bits itself. After exactly 160 bits it stops and pulls its enable output low for one strobe period, so the next chip in the chain takes over on the following strobe.

The control path is one state machine with four states. `ST_IDLE` means deselected and done. `ST_ARMED` waits for the enable input. `ST_LOAD` takes data. `ST_PULSE` holds the enable output low. Its transitions are:
- `ARM` (latch-pulse falling edge, from any state, to `ST_ARMED`)
- `SELECT` (strobe with enable input low, `ST_ARMED` to `ST_LOAD`)
- `FILL_DONE` (the strobe that brings the count to 160, to `ST_PULSE`, taken from `ST_ARMED` or `ST_LOAD`)
- `HAND_OFF` (next strobe, `ST_PULSE` to `ST_IDLE`)

Top module: `seg_loader`

## Requirements
- R1: With `wide_mode` low, each accepted strobe takes the 4 bits `din[3:0]`, and 40 accepted strobes fill all 160 positions.
- R2: With `wide_mode` high, each accepted strobe takes the 8 bits `din[7:0]`, and 20 accepted strobes fill all 160 positions.
- R3: With `fill_up` high, data fills positions 1 to 160 in order, and bit `din[j]` goes to position count+1+j. With `fill_up` low, data fills positions 160 down to 1, and `din[j]` goes to position 160-count-j. Position p is driven on `drv_code[2p-1:2p-2]`.
- R4: With `fill_up` low, pin 1 is the enable output (`eio1_oe`=1) and pin 2 is the enable input. With `fill_up` high, the roles swap. A pin that is not driving shows `_o`=1 and `_oe`=0.
- R5: A latch-pulse falling edge clears the bit count and arms the chip. Strobes are ignored until one arrives with the enable input low, and that strobe is already taken.
- R6: Once 160 bits are taken, further strobes change nothing until the next latch-pulse falling edge.
- R7: The enable output is high, except that it goes low right after the strobe that completes 160 bits and returns high at the next strobe.
- R8: The line latch takes the data latch on the clock edge where `lat_pulse` is first seen low after being high. Otherwise it holds.
- R9: While `blank_n` is low, every output code is 3 and the line latch is cleared, but the data latch keeps loading.
- R10: After `blank_n` returns high, every output shows a deselect level until the next latch-pulse falling edge.
- R11: Code 0=V0, 1=V12, 2=V43, 3=V5. A set pixel gives 0 when `frame` is high and 3 when it is low. A clear pixel gives 1 when `frame` is high and 2 when it is low.
- R12: A synchronous active-low reset clears the count, both latches and the selected state, and drives the enable output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_stb | input | 1 | One-cycle strobe marking a data shift-clock falling edge |
| lat_pulse | input | 1 | Line latch pulse level; its falling edge matters |
| wide_mode | input | 1 | 0: 4 bits per strobe, 1: 8 bits per strobe |
| fill_up | input | 1 | Fill direction and enable pin roles |
| blank_n | input | 1 | Active-low display blanking |
| frame | input | 1 | Frame inversion signal |
| din | input | 8 | Pixel data bus |
| eio1_i | input | 1 | Enable pin 1 input value |
| eio2_i | input | 1 | Enable pin 2 input value |
| eio1_o | output | 1 | Enable pin 1 output value |
| eio1_oe | output | 1 | Enable pin 1 output enable |
| eio2_o | output | 1 | Enable pin 2 output value |
| eio2_oe | output | 1 | Enable pin 2 output enable |
| drv_code | output | 320 | Two-bit drive-level code per column |

## Verification
The state machine, the count and the data latch change on the clock edge that samples a strobe. The enable output and the data latch are therefore correct one edge after the strobe is applied. The line latch loads on the first edge that sees `lat_pulse` low after it was high. Codes follow `frame` and `blank_n` in the same cycle. The bench changes inputs on the falling clock edge, then lets exactly the number of rising edges the requirement names go by. It samples on the next falling edge, so every comparison reads a settled value.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOAD  = 2'd2,
        ST_PULSE = 2'd3
    } ld_state_t;

    localparam logic [1:0] LVL_V0  = 2'd0;
    localparam logic [1:0] LVL_V12 = 2'd1;
    localparam logic [1:0] LVL_V43 = 2'd2;
    localparam logic [1:0] LVL_V5  = 2'd3;

    function automatic logic [1:0] drive_level(input logic pix, input logic frm, input logic on_n);
        logic [1:0] lvl;
        if (!on_n)
            lvl = LVL_V5;
        else if (pix)
            lvl = frm ? LVL_V0 : LVL_V5;
        else
            lvl = frm ? LVL_V12 : LVL_V43;
        return lvl;
    endfunction

endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
    import seg_loader_pkg::*;
#(
    parameter int NUM_OUT = 160,
    parameter int BUS_W   = 8,
    parameter int CNT_W   = $clog2(NUM_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_stb,
    input  logic             lat_pulse,
    input  logic             wide_mode,
    input  logic             enab_in,
    output logic             lp_fall,
    output logic             take,
    output logic             enab_out,
    output logic [CNT_W-1:0] cnt
);

    localparam int NARROW = BUS_W / 2;
    localparam int SUM_W  = CNT_W + 1;

    ld_state_t        state_q, state_d;
    logic             lp_q;
    logic [SUM_W-1:0] cnt_sum;
    logic             fill_done;

    // latch pulse edge detector
    always_ff @(posedge clk) begin
        if (!rst_n)
            lp_q <= 1'b0;
        else
            lp_q <= lat_pulse;
    end

    assign lp_fall   = lp_q & ~lat_pulse;
    assign cnt_sum   = SUM_W'(cnt) + (wide_mode ? SUM_W'(BUS_W) : SUM_W'(NARROW));
    assign fill_done = (cnt_sum >= SUM_W'(NUM_OUT));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (lp_fall) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: if (take) state_d = fill_done ? ST_PULSE : ST_LOAD;
                ST_LOAD:  if (take && fill_done) state_d = ST_PULSE;
                ST_PULSE: if (shift_stb) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        take     = 1'b0;
        enab_out = 1'b1;
        unique case (state_q)
            ST_IDLE:  take = 1'b0;
            ST_ARMED: take = shift_stb & ~enab_in & ~lp_fall;
            ST_LOAD:  take = shift_stb & ~lp_fall;
            ST_PULSE: enab_out = 1'b0;
            default:  take = 1'b0;
        endcase
    end

    // bit counter
    always_ff @(posedge clk) begin
        if (!rst_n || lp_fall)
            cnt <= '0;
        else if (take)
            cnt <= fill_done ? CNT_W'(NUM_OUT) : cnt_sum[CNT_W-1:0];
    end

endmodule

// File: rtl/seg_fill.sv
module seg_fill #(
    parameter int NUM_OUT = 160,
    parameter int BUS_W   = 8,
    parameter int CNT_W   = $clog2(NUM_OUT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               wide_mode,
    input  logic               fill_up,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [BUS_W-1:0]   din,
    output logic [NUM_OUT-1:0] data_q
);

    localparam int NARROW = BUS_W / 2;
    localparam int IDX_W  = (BUS_W > 1) ? $clog2(BUS_W) : 1;

    logic [NUM_OUT-1:0] data_d;
    int                 step;

    assign step = wide_mode ? BUS_W : NARROW;

    // window select: each column picks its bus bit when the fill window covers it
    always_comb begin
        int off;
        data_d = data_q;
        off    = 0;
        if (take) begin
            for (int i = 0; i < NUM_OUT; i++) begin
                off = fill_up ? (i - int'(cnt)) : (NUM_OUT - 1 - i - int'(cnt));
                if (off >= 0 && off < step)
                    data_d[i] = din[off[IDX_W-1:0]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else
            data_q <= data_d;
    end

endmodule

// File: rtl/seg_line.sv
module seg_line
    import seg_loader_pkg::*;
#(
    parameter int NUM_OUT = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lp_fall,
    input  logic                 blank_n,
    input  logic                 frame,
    input  logic [NUM_OUT-1:0]   data_q,
    output logic [NUM_OUT-1:0]   line_q,
    output logic [2*NUM_OUT-1:0] drv_code
);

    always_ff @(posedge clk) begin
        if (!rst_n || !blank_n)
            line_q <= '0;
        else if (lp_fall)
            line_q <= data_q;
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_col
        assign drv_code[2*g +: 2] = drive_level(line_q[g], frame, blank_n);
    end

endmodule

// File: rtl/seg_loader.sv
module seg_loader #(
    parameter int NUM_OUT = 160,
    parameter int BUS_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_stb,
    input  logic                 lat_pulse,
    input  logic                 wide_mode,
    input  logic                 fill_up,
    input  logic                 blank_n,
    input  logic                 frame,
    input  logic [BUS_W-1:0]     din,
    input  logic                 eio1_i,
    input  logic                 eio2_i,
    output logic                 eio1_o,
    output logic                 eio1_oe,
    output logic                 eio2_o,
    output logic                 eio2_oe,
    output logic [2*NUM_OUT-1:0] drv_code
);

    localparam int CNT_W = $clog2(NUM_OUT + 1);

    logic               lp_fall;
    logic               take;
    logic               enab_in;
    logic               enab_out;
    logic [CNT_W-1:0]   bit_cnt;
    logic [NUM_OUT-1:0] data_q;
    logic [NUM_OUT-1:0] line_q;

    // enable pin roles follow the fill direction
    assign enab_in = fill_up ? eio1_i : eio2_i;
    assign eio1_oe = ~fill_up;
    assign eio2_oe = fill_up;
    assign eio1_o  = fill_up ? 1'b1 : enab_out;
    assign eio2_o  = fill_up ? enab_out : 1'b1;

    seg_ctrl #(.NUM_OUT(NUM_OUT), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_stb (shift_stb),
        .lat_pulse (lat_pulse),
        .wide_mode (wide_mode),
        .enab_in   (enab_in),
        .lp_fall   (lp_fall),
        .take      (take),
        .enab_out  (enab_out),
        .cnt       (bit_cnt)
    );

    seg_fill #(.NUM_OUT(NUM_OUT), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .wide_mode (wide_mode),
        .fill_up   (fill_up),
        .cnt       (bit_cnt),
        .din       (din),
        .data_q    (data_q)
    );

    seg_line #(.NUM_OUT(NUM_OUT)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .lp_fall  (lp_fall),
        .blank_n  (blank_n),
        .frame    (frame),
        .data_q   (data_q),
        .line_q   (line_q),
        .drv_code (drv_code)
    );

endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk #(
    parameter int NUM_OUT = 160,
    parameter int CNT_W   = $clog2(NUM_OUT + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 shift_stb,
    input logic                 lat_pulse,
    input logic                 blank_n,
    input logic                 fill_up,
    input logic                 eio1_o,
    input logic                 eio2_o,
    input logic [2*NUM_OUT-1:0] drv_code,
    input logic [CNT_W-1:0]     cnt,
    input logic [NUM_OUT-1:0]   line_q
);

    logic lp_seen;
    logic lp_edge;
    logic enab;

    always_ff @(posedge clk) begin
        if (!rst_n)
            lp_seen <= 1'b0;
        else
            lp_seen <= lat_pulse;
    end

    assign lp_edge = lp_seen & ~lat_pulse;
    assign enab    = fill_up ? eio2_o : eio1_o;

    function automatic logic all_desel(input logic [2*NUM_OUT-1:0] c);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_OUT; i++)
            ok = ok & (c[2*i] ^ c[2*i+1]);
        return ok;
    endfunction

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_W'(NUM_OUT)); // R6
    AST_COUNT_REARM: assert property (@(posedge clk) disable iff (!rst_n) lp_edge |=> cnt == '0); // R5
    AST_ENAB_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) (!enab && shift_stb) |=> enab); // R7
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (blank_n && !lp_edge) |=> $stable(line_q)); // R8
    AST_BLANK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !blank_n |=> line_q == '0); // R9
    AST_DESEL_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n) $rose(blank_n) |-> all_desel(drv_code)); // R10
    AST_RESET_ENAB: assert property (@(posedge clk) !rst_n |=> enab); // R12

endmodule

bind seg_loader seg_loader_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_stb (shift_stb),
    .lat_pulse (lat_pulse),
    .blank_n   (blank_n),
    .fill_up   (fill_up),
    .eio1_o    (eio1_o),
    .eio2_o    (eio2_o),
    .drv_code  (drv_code),
    .cnt       (bit_cnt),
    .line_q    (line_q)
);

// File: tb/sim_seg_loader.sv
module sim_seg_loader;

    localparam int N = 160;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           shift_stb = 1'b0;
    logic           lat_pulse = 1'b0;
    logic           wide_mode = 1'b0;
    logic           fill_up = 1'b1;
    logic           blank_n = 1'b1;
    logic           frame = 1'b1;
    logic [7:0]     din = '0;
    logic           eio1_i = 1'b0;
    logic           eio2_i = 1'b1;
    logic           eio1_o, eio1_oe, eio2_o, eio2_oe;
    logic [2*N-1:0] drv_code;

    seg_loader u0 (
        .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .lat_pulse(lat_pulse),
        .wide_mode(wide_mode), .fill_up(fill_up), .blank_n(blank_n), .frame(frame),
        .din(din), .eio1_i(eio1_i), .eio2_i(eio2_i), .eio1_o(eio1_o), .eio1_oe(eio1_oe),
        .eio2_o(eio2_o), .eio2_oe(eio2_oe), .drv_code(drv_code)
    );

    always #10 clk = ~clk;

    typedef struct {
        string          req;
        bit             is_pin;
        logic [2*N-1:0] exp;
    } item_t;

    item_t    sb[$];
    event     sample_ev;
    int       n_chk = 0;
    int       n_bad = 0;
    bit       finished = 1'b0;

    // reference state built from the requirements
    logic [N-1:0] m_data = '0;
    logic [N-1:0] m_line = '0;
    int           m_cnt = 0;
    bit           m_armed = 1'b0;
    bit           m_load = 1'b0;
    bit           m_pulse = 1'b0;

    function automatic logic [2*N-1:0] exp_codes();
        logic [2*N-1:0] c;
        for (int i = 0; i < N; i++) begin
            if (!blank_n)         c[2*i +: 2] = 2'd3;
            else if (m_line[i])   c[2*i +: 2] = frame ? 2'd0 : 2'd3;
            else                  c[2*i +: 2] = frame ? 2'd1 : 2'd2;
        end
        return c;
    endfunction

    function automatic logic [2*N-1:0] exp_pins();
        logic en;
        en = ~m_pulse;
        // {eio1_o, eio1_oe, eio2_o, eio2_oe}
        return fill_up ? {{(2*N-4){1'b0}}, 1'b1, 1'b0, en, 1'b1}
                       : {{(2*N-4){1'b0}}, en, 1'b1, 1'b1, 1'b0};
    endfunction

    task automatic push_codes(input string req);
        item_t it;
        it.req = req; it.is_pin = 1'b0; it.exp = exp_codes();
        sb.push_back(it);
    endtask

    task automatic push_pins(input string req);
        item_t it;
        it.req = req; it.is_pin = 1'b1; it.exp = exp_pins();
        sb.push_back(it);
    endtask

    // monitor: pops expectations and compares at the sampling point
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [2*N-1:0] act;
                it = sb.pop_front();
                act = it.is_pin ? {{(2*N-4){1'b0}}, eio1_o, eio1_oe, eio2_o, eio2_oe} : drv_code;
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic sample();
        -> sample_ev;
        #1;
    endtask

    task automatic strobe(input logic [7:0] w, input string req);
        bit en_low;
        int step;
        @(negedge clk);
        din = w; shift_stb = 1'b1;
        @(negedge clk);
        shift_stb = 1'b0;
        en_low = fill_up ? !eio1_i : !eio2_i;
        step = wide_mode ? 8 : 4;
        if (m_load || (m_armed && en_low)) begin
            for (int j = 0; j < step; j++) begin
                if (fill_up) m_data[m_cnt + j] = w[j];
                else         m_data[N - 1 - m_cnt - j] = w[j];
            end
            m_armed = 1'b0; m_load = 1'b1;
            m_cnt += step;
            if (m_cnt >= N) begin m_load = 1'b0; m_pulse = 1'b1; end
        end else if (m_pulse) begin
            m_pulse = 1'b0;
        end
        push_pins(req);
        sample();
    endtask

    task automatic lpulse(input string req);
        @(negedge clk); lat_pulse = 1'b1;
        @(negedge clk); lat_pulse = 1'b0;
        @(negedge clk);
        m_armed = 1'b1; m_load = 1'b0; m_pulse = 1'b0; m_cnt = 0;
        m_line = blank_n ? m_data : '0;
        push_codes(req);
        push_pins(req);
        sample();
    endtask

    task automatic set_ctl(input logic b, input logic f, input string req);
        @(negedge clk); blank_n = b; frame = f;
        @(negedge clk);
        if (!b) m_line = '0;
        push_codes(req);
        sample();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        m_data = '0; m_line = '0; m_cnt = 0;
        m_armed = 1'b0; m_load = 1'b0; m_pulse = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        push_codes("R12 reset codes"); push_pins("R12 reset enable");
        sample();

        // R1/R3 narrow fill upward, R7 hand-off, R6 stop
        fill_up = 1'b1; wide_mode = 1'b0; eio1_i = 1'b0;
        lpulse("R8 first latch");
        for (int k = 0; k < 40; k++) strobe(8'(k * 29 + 3), "R7 narrow enable");
        strobe(8'hFF, "R6 extra strobe ignored, R7 return high");
        lpulse("R1 R3 narrow up line");
        set_ctl(1'b1, 1'b0, "R11 frame low");

        // R4 roles, R5 gating, R2/R3 wide downward fill
        fill_up = 1'b0; eio2_i = 1'b1; wide_mode = 1'b1;
        lpulse("R4 R8 relatch");
        for (int k = 0; k < 3; k++) strobe(8'hFF, "R5 strobe before select");
        eio2_i = 1'b0;
        for (int k = 0; k < 20; k++) strobe(8'(k * 53 + 17), "R4 R7 wide enable");
        lpulse("R2 R3 wide down line");
        set_ctl(1'b1, 1'b1, "R11 frame high");

        // R9/R10 blanking
        set_ctl(1'b0, 1'b1, "R9 blank forces V5");
        fill_up = 1'b1; eio1_i = 1'b0;
        lpulse("R9 latch during blank");
        for (int k = 0; k < 20; k++) strobe(8'(k * 71 + 90), "R9 load during blank");
        set_ctl(1'b0, 1'b0, "R9 still blank");
        set_ctl(1'b1, 1'b1, "R10 deselect after release");
        lpulse("R9 R10 data shown after latch");

        // R12 reset mid-line
        lpulse("R8 arm before reset");
        for (int k = 0; k < 5; k++) strobe(8'hA5, "R5 partial load");
        do_reset();
        @(negedge clk);
        push_codes("R12 reset clears line"); push_pins("R12 reset enable high");
        sample();
        for (int k = 0; k < 3; k++) strobe(8'hFF, "R12 deselected after reset");
        lpulse("R12 data latch cleared");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule